// File: doc/BRIEF.md
# Tape Formatter Register File and Command Dispatcher

This block is the register front end of a magnetic tape formatter. A host reaches it over a simple register bus: a 4-bit offset, 16-bit write data, a write strobe and a read strobe. Read data appears one cycle after the read strobe. Inside are a control word (function code plus GO), the frame count, the formatter status, an error register, an attention summary, tape control and a constant drive type word.

When the host writes a function with GO set, the block checks whether the command is legal. The check looks at the error state, the selected drive's status lines, the frame-count-loaded flag, density, format and write lock. A legal command either finishes at once or sends a one-cycle start pulse, with the function code and drive number, to an external transport model. An illegal command sets an error bit, drops GO and raises attention. The transport reports completion on a done strobe, which may carry a tape-mark flag and a frame-count error flag.

Register offsets: 0 control, 1 status, 2 error, 3 attention, 4 frame count, 5 tape control, 6 drive type. Reads of every other offset return zero, and writes to them are ignored.

Top module: `tape_fmt_regs`

## Requirements
- R1: Reading control (offset 0) returns the last written bits 5:0 (bit 0 GO, bits 5:1 function) with bit 11 (0x0800) always set and every other bit zero. Unmapped offsets read as zero.
- R2: While GO is set, a write to offset 0, 1, 2, 4, 5 or 6 leaves every register unchanged and sets error bit 2.
- R3: A command other than formatter clear (function 4) is illegal when the error register is nonzero or drv_busy is high. An unsupported function code (anything outside 0,1,3,4,8,10,11,12,13,20,23,24,28,31) is also illegal. An illegal command sets error bit 0, clears GO and sends no start pulse.
- R4: Writing the frame count (offset 4) stores the value and sets tape control bit 14 (frame count loaded).
- R5: Formatter clear zeroes the error register, clears tape control bit 14 and status bit 6, clears GO and sends no start pulse.
- R6: Error bit 11 (cannot execute) is set by any of the following: space forward (12) with bit 14 clear or at end of tape; space reverse (13) with bit 14 clear or at beginning of tape; reverse reads (23, 31) at beginning of tape; write (24) with bit 14 clear, or with density code 3 and a frame count above 0xFFF5; write, erase (10) or tape mark (11) on a write-locked drive.
- R7: Whenever an error bit becomes set, attention goes high. Attention is visible on the attn pin, at status bit 15 and at attention register bit 0. Writing offset 3 with bit 0 set clears attention. Writing offset 3 with bit 0 clear has no effect.
- R8: Data commands (10, 11, 20, 23, 24, 28, 31) on a drive that is not online set error bit 14. On an online drive whose format field (tape control bits 7:4) is neither 12 nor 13, they set error bit 4.
- R9: Read-in preset (8) loads tape control with 0x03C0 (density 3, format 12, drive 0) and sends a start pulse with function 8 to drive 0.
- R10: An accepted command clears attention and tape control bit 13. Every accepted command except no-op and formatter clear sends a one-cycle drv_start with drv_func set to the function and drv_sel set to tape control bits 2:0. GO stays set only for space and data commands.
- R11: drv_done while GO is set clears GO, and sets attention only if the function was below 20. drv_done while GO is clear sets attention and status bit 6. done_tmk sets status bit 2. done_fce sets error bit 9.
- R12: Status bit 8 is always 1. Bit 7 (ready) is 1 exactly when GO is clear and drv_busy is low. Bit 14 is 1 exactly when the error register is nonzero. Bits 13, 12, 11, 10 and 1 report drive busy, online, and (only when online) write lock, end of tape and beginning of tape.
- R13: A write to tape control stores only bits 10:0 and 12. The same write sets bit 13 and leaves bit 14 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data valid next cycle |
| reg_rdata | output | 16 | Registered read data |
| attn | output | 1 | Attention active |
| drv_start | output | 1 | One-cycle operation start to transport |
| drv_func | output | 5 | Function code of the started operation |
| drv_sel | output | 3 | Drive number of the started operation |
| drv_online | input | 1 | Selected drive has medium online |
| drv_busy | input | 1 | Selected drive is moving |
| drv_bot | input | 1 | Selected drive is at beginning of tape |
| drv_eot | input | 1 | Selected drive is past end of tape |
| drv_wlock | input | 1 | Selected drive is write locked |
| drv_done | input | 1 | Operation completion strobe |
| done_tmk | input | 1 | With done: a tape mark was crossed |
| done_fce | input | 1 | With done: frame count error |

## Verification
The hardest cases to reach are the ones where several conditions must line up before a command is issued. Examples are a write at density 3 with the frame count just above the limit and the loaded flag set, or a reverse read on an online drive sitting at beginning of tape. The random loop gets there by clearing the formatter first on every pass. It then draws the drive status lines, picks a format that is usually valid, and loads the frame count only on some passes. About half the frame counts are drawn from the band around 0xFFF5. A bench function predicts the error word from the same inputs. Directed steps cover the remaining cases: a write refused while GO is set, completion of a rewind, and the attention write with bit 0 clear.

// File: rtl/tape_fmt_regs.sv
module tape_fmt_regs #(
  parameter logic [15:0] DRIVE_TYPE = 16'hC049,
  parameter logic [15:0] FC_MAX_NRZ = 16'hFFF5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  output logic [15:0] reg_rdata,
  output logic        attn,
  output logic        drv_start,
  output logic [4:0]  drv_func,
  output logic [2:0]  drv_sel,
  input  logic        drv_online,
  input  logic        drv_busy,
  input  logic        drv_bot,
  input  logic        drv_eot,
  input  logic        drv_wlock,
  input  logic        drv_done,
  input  logic        done_tmk,
  input  logic        done_fce
);

  localparam logic [3:0] A_CS = 4'd0, A_ST = 4'd1, A_ER = 4'd2, A_AT = 4'd3,
                         A_FC = 4'd4, A_TC = 4'd5, A_DT = 4'd6;
  localparam logic [4:0] F_NOP = 5'd0, F_UNL = 5'd1, F_REW = 5'd3, F_CLR = 5'd4,
                         F_RIP = 5'd8, F_ERA = 5'd10, F_WTM = 5'd11, F_SPF = 5'd12,
                         F_SPR = 5'd13, F_WCF = 5'd20, F_WCR = 5'd23, F_WR = 5'd24,
                         F_RDF = 5'd28, F_RDR = 5'd31;
  localparam logic [15:0] E_ILF = 16'h0001, E_RMR = 16'h0004, E_FER = 16'h0010,
                          E_FCE = 16'h0200, E_NXF = 16'h0800, E_UNS = 16'h4000;
  localparam logic [15:0] TC_WMASK = 16'h17FF;
  localparam logic [15:0] TC_PRESET = 16'h03C0;

  logic [5:0]  cs_q;
  logic [15:0] fc_q, er_q, tc_q;
  logic        ata_q, tmk_q, ssc_q;
  logic [4:0]  act_fn_q;

  wire       go     = cs_q[0];
  wire [4:0] fn     = reg_wdata[5:1];
  wire [3:0] fmt    = tc_q[7:4];
  wire [2:0] den    = tc_q[10:8];
  wire       fcs    = tc_q[14];
  wire       bot_st = drv_online & drv_bot;
  wire       eot_st = drv_online & drv_eot;
  wire       wl_st  = drv_online & drv_wlock;

  wire guarded = (reg_addr == A_CS) | (reg_addr == A_ST) | (reg_addr == A_ER) |
                 (reg_addr == A_FC) | (reg_addr == A_TC) | (reg_addr == A_DT);
  wire refuse  = reg_wr & go & guarded;
  wire wr_ok   = reg_wr & ~refuse;
  wire cmd     = wr_ok & (reg_addr == A_CS) & reg_wdata[0];

  logic [15:0] cmd_err;
  logic        acc, start, keep_go;

  always_comb begin
    cmd_err = '0;
    acc = 1'b0;
    start = 1'b0;
    keep_go = 1'b0;
    if (cmd) begin
      if (fn != F_CLR && (er_q != 16'h0 || drv_busy)) cmd_err = E_ILF;
      else begin
        case (fn)
          F_NOP, F_CLR: acc = 1'b1;
          F_RIP: begin acc = 1'b1; start = 1'b1; end
          F_UNL, F_REW:
            if (!drv_online) cmd_err = E_UNS;
            else begin acc = 1'b1; start = 1'b1; end
          F_SPF, F_SPR:
            if (!drv_online) cmd_err = E_UNS;
            else if (!fcs || (fn == F_SPF ? eot_st : bot_st)) cmd_err = E_NXF;
            else begin acc = 1'b1; start = 1'b1; keep_go = 1'b1; end
          F_ERA, F_WTM, F_WCF, F_WCR, F_WR, F_RDF, F_RDR: begin
            if ((fn == F_WCR || fn == F_RDR) && bot_st) cmd_err = E_NXF;
            else if (fn == F_WR && (!fcs || (den == 3'd3 && fc_q > FC_MAX_NRZ))) cmd_err = E_NXF;
            else if ((fn == F_WR || fn == F_ERA || fn == F_WTM) && wl_st) cmd_err = E_NXF;
            else if (!drv_online) cmd_err = E_UNS;
            else if (fmt != 4'd12 && fmt != 4'd13) cmd_err = E_FER;
            else begin acc = 1'b1; start = 1'b1; keep_go = 1'b1; end
          end
          default: cmd_err = E_ILF;
        endcase
      end
    end
  end

  wire [15:0] er_set  = (refuse ? E_RMR : 16'h0) | cmd_err |
                        ((drv_done & done_fce) ? E_FCE : 16'h0);
  wire        clr_cmd = acc & (fn == F_CLR);
  wire        ata_set = (er_set != 16'h0) | (drv_done & (~go | (act_fn_q < F_WCF)));
  wire        ata_clr = acc | (wr_ok & (reg_addr == A_AT) & reg_wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= '0;
      fc_q      <= '0;
      er_q      <= '0;
      tc_q      <= '0;
      ata_q     <= 1'b0;
      tmk_q     <= 1'b0;
      ssc_q     <= 1'b0;
      act_fn_q  <= '0;
      drv_start <= 1'b0;
      drv_func  <= '0;
      drv_sel   <= '0;
    end else begin
      drv_start <= 1'b0;
      er_q  <= (clr_cmd ? 16'h0 : er_q) | er_set;
      ata_q <= ata_set | (ata_q & ~ata_clr);
      if (wr_ok && reg_addr == A_CS) begin
        cs_q <= reg_wdata[5:0];
        if (cmd && !keep_go) cs_q[0] <= 1'b0;
      end
      if (wr_ok && reg_addr == A_FC) begin
        fc_q     <= reg_wdata;
        tc_q[14] <= 1'b1;
      end
      if (wr_ok && reg_addr == A_TC)
        tc_q <= (tc_q & ~TC_WMASK) | (reg_wdata & TC_WMASK) | 16'h2000;
      if (acc) begin
        tc_q[13] <= 1'b0;
        if (fn == F_CLR) begin
          tc_q[14] <= 1'b0;
          ssc_q    <= 1'b0;
        end
        if (fn == F_RIP) tc_q <= TC_PRESET;
        if (start) begin
          tmk_q     <= 1'b0;
          drv_start <= 1'b1;
          drv_func  <= fn;
          drv_sel   <= (fn == F_RIP) ? 3'd0 : tc_q[2:0];
          act_fn_q  <= fn;
        end
      end
      if (drv_done) begin
        if (go) cs_q[0] <= 1'b0;
        else ssc_q <= 1'b1;
        if (done_tmk) tmk_q <= 1'b1;
      end
    end
  end

  wire        rdy    = ~go & ~drv_busy;
  wire [15:0] status = {ata_q, (er_q != 16'h0), drv_busy, drv_online, wl_st, eot_st,
                        1'b0, 1'b1, rdy, ssc_q, 3'b000, tmk_q, bot_st, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_CS:    reg_rdata <= {4'h0, 1'b1, 5'h0, cs_q};
        A_ST:    reg_rdata <= status;
        A_ER:    reg_rdata <= er_q;
        A_AT:    reg_rdata <= {15'h0, ata_q};
        A_FC:    reg_rdata <= fc_q;
        A_TC:    reg_rdata <= tc_q;
        A_DT:    reg_rdata <= DRIVE_TYPE;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign attn = ata_q;

endmodule

// File: rtl/tape_fmt_chk.sv
module tape_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_rdata,
  input logic        attn,
  input logic        drv_start,
  input logic [4:0]  drv_func,
  input logic [2:0]  drv_sel,
  input logic        drv_done,
  input logic [5:0]  cs_q,
  input logic [15:0] er_q
);

  p_dva_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 4'd0) |=> reg_rdata[11]);

  p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cs_q[0] && reg_addr == 4'd4) |=> er_q[2]);

  p_start_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_start |-> ($past(er_q) == 16'h0));

  p_err_attn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((er_q & ~$past(er_q)) != 16'h0) |-> attn);

  p_attn_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd3 && reg_wdata[0] && !drv_done) |=> !attn);

  p_preset_drive0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_start && drv_func == 5'd8) |-> drv_sel == 3'd0);

  p_done_drops_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_done && cs_q[0]) |=> !cs_q[0]);

endmodule

bind tape_fmt_regs tape_fmt_chk u_chk (.*);

// File: tb/sim_tape_fmt_regs.sv
module sim_tape_fmt_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic attn, drv_start;
  logic [4:0] drv_func;
  logic [2:0] drv_sel;
  logic drv_online = 0, drv_busy = 0, drv_bot = 0, drv_eot = 0, drv_wlock = 0;
  logic drv_done = 0, done_tmk = 0, done_fce = 0;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tape_fmt_regs u0 (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic done_pulse(logic tmk);
    @(negedge clk); drv_done = 1; done_tmk = tmk;
    @(negedge clk); drv_done = 0; done_tmk = 0;
  endtask

  function automatic logic [15:0] cmdw(logic [4:0] f);
    return {10'h0, f, 1'b1};
  endfunction

  function automatic logic [15:0] pred_err(logic [4:0] f, logic busy, logic onl, logic bot,
      logic eot, logic wl, logic fcs, logic [2:0] den, logic [15:0] fc, logic [3:0] fmt);
    logic b = onl & bot, e = onl & eot, w = onl & wl;
    logic data = (f == 10 || f == 11 || f == 20 || f == 23 || f == 24 || f == 28 || f == 31);
    if (f != 4 && busy) return 16'h0001;
    if (f == 0 || f == 4 || f == 8) return 0;
    if (f == 1 || f == 3) return onl ? 16'h0 : 16'h4000;
    if (f == 12 || f == 13) begin
      if (!onl) return 16'h4000;
      if (!fcs || (f == 12 ? e : b)) return 16'h0800;
      return 0;
    end
    if (!data) return 16'h0001;
    if ((f == 23 || f == 31) && b) return 16'h0800;
    if (f == 24 && (!fcs || (den == 3 && fc > 16'hFFF5))) return 16'h0800;
    if ((f == 24 || f == 10 || f == 11) && w) return 16'h0800;
    if (!onl) return 16'h4000;
    if (fmt != 12 && fmt != 13) return 16'h0010;
    return 0;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, d); check("R1 reset ctrl", d, 16'h0800);
    rd(1, d); check("R12 reset status", d, 16'h0180);
    rd(2, d); check("R7 reset error", d, 16'h0000);
    check("R7 reset attn", attn, 0);
    rd(9, d); check("R1 unmapped read", d, 16'h0000);

    wr(5, 16'hFFFF); rd(5, d); check("R13 tc mask", d, 16'h37FF);
    wr(4, 16'h1234); rd(4, d); check("R4 fc value", d, 16'h1234);
    rd(5, d); check("R4 fc flag", d, 16'h77FF);

    drv_online = 1;
    wr(5, 16'h04C5);
    wr(0, cmdw(28));
    check("R10 start", drv_start, 1);
    check("R10 func", drv_func, 28);
    check("R10 sel", drv_sel, 5);
    rd(0, d); check("R10 go kept", d, 16'h0839);
    rd(1, d); check("R12 not ready", d[7], 0);
    rd(5, d); check("R10 sac cleared", d[13], 0);

    wr(4, 16'h0000); rd(4, d); check("R2 fc unchanged", d, 16'h1234);
    rd(2, d); check("R2 refused bit", d, 16'h0004);
    check("R7 attn on error", attn, 1);
    wr(3, 16'h0000); check("R7 attn write bit0 clear", attn, 1);
    wr(3, 16'h0001); check("R7 attn cleared", attn, 0);

    done_pulse(1);
    rd(0, d); check("R11 go cleared", d, 16'h0838);
    check("R11 transfer no attn", attn, 0);
    rd(1, d); check("R11 tape mark", d[2], 1);
    check("R12 error summary", d[14], 1);

    wr(0, cmdw(0));
    rd(2, d); check("R3 cmd with error", d, 16'h0005);
    check("R3 attn", attn, 1);
    rd(0, d); check("R3 go dropped", d, 16'h0800);

    wr(0, cmdw(4));
    check("R5 no start", drv_start, 0);
    rd(2, d); check("R5 err zero", d, 16'h0000);
    rd(5, d); check("R5 fcs cleared", d[14], 0);
    check("R10 attn cleared", attn, 0);

    wr(0, cmdw(12)); rd(2, d); check("R6 space no fcs", d, 16'h0800);
    wr(0, cmdw(4));
    wr(5, 16'h03C0); wr(4, 16'hFFF6); wr(0, cmdw(24));
    rd(2, d); check("R6 write nrz fc", d, 16'h0800);
    wr(0, cmdw(4)); wr(4, 16'hFFF5); wr(0, cmdw(24));
    check("R6 write at limit starts", drv_start, 1);
    done_pulse(0); wr(0, cmdw(4));
    drv_wlock = 1; wr(0, cmdw(10)); rd(2, d); check("R6 erase wlock", d, 16'h0800);
    drv_wlock = 0; wr(0, cmdw(4));
    drv_bot = 1; wr(0, cmdw(31)); rd(2, d); check("R6 read rev bot", d, 16'h0800);
    drv_bot = 0; wr(0, cmdw(4));

    wr(5, 16'h0000); wr(0, cmdw(28)); rd(2, d); check("R8 bad format", d, 16'h0010);
    wr(0, cmdw(4)); drv_online = 0; wr(5, 16'h00C0); wr(0, cmdw(28));
    rd(2, d); check("R8 offline", d, 16'h4000);
    wr(0, cmdw(4)); drv_online = 1;

    wr(5, 16'h0007); wr(0, cmdw(8));
    check("R9 start", drv_start, 1); check("R9 func", drv_func, 8); check("R9 sel", drv_sel, 0);
    rd(5, d); check("R9 tc preset", d, 16'h03C0);

    wr(0, cmdw(3));
    check("R10 rewind start", drv_start, 1);
    rd(0, d); check("R10 rewind go clear", d, 16'h0806);
    done_pulse(0);
    check("R11 rewind done attn", attn, 1);
    rd(1, d); check("R11 ssc", d[6], 1);
    wr(0, cmdw(4)); rd(1, d); check("R5 ssc cleared", d[6], 0);

    drv_busy = 1; wr(0, cmdw(28)); rd(2, d); check("R3 busy", d, 16'h0001);
    rd(1, d); check("R12 busy not ready", d[7], 0);
    drv_busy = 0; wr(0, cmdw(4));
    wr(0, cmdw(2)); rd(2, d); check("R3 unsupported", d, 16'h0001);
    wr(0, cmdw(4));

    for (int i = 0; i < 300; i++) begin
      logic [4:0] f; logic [15:0] tcv, fcv, pe; logic ld; logic [3:0] fm;
      f = 5'($urandom_range(0, 31));
      fm = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'(12 + $urandom_range(0, 1));
      tcv = {5'h0, 3'($urandom), fm, 4'($urandom)};
      fcv = $urandom_range(0, 1) ? 16'($urandom_range(16'hFFF0, 16'hFFFF)) : 16'($urandom);
      ld = $urandom_range(0, 3) != 0;
      drv_busy = $urandom_range(0, 7) == 0;
      drv_online = $urandom_range(0, 4) != 0;
      drv_bot = $urandom_range(0, 4) == 0;
      drv_eot = $urandom_range(0, 4) == 0;
      drv_wlock = $urandom_range(0, 4) == 0;
      wr(0, cmdw(4));
      wr(5, tcv);
      if (ld) wr(4, fcv);
      pe = pred_err(f, drv_busy, drv_online, drv_bot, drv_eot, drv_wlock, ld,
                    tcv[10:8], fcv, tcv[7:4]);
      wr(0, cmdw(f));
      if (pe == 0 && f != 0 && f != 4) begin
        check("R10 rnd start", drv_start, 1);
        check("R10 rnd func", drv_func, f);
        check("R10 rnd sel", drv_sel, (f == 8) ? 3'd0 : tcv[2:0]);
      end else check("R3 rnd no start", drv_start, 0);
      check("R7 rnd attn", attn, pe != 0);
      if (pe == 0 && (f == 12 || f == 13 || f >= 10 && f != 8 && f != 0)) begin
        done_pulse(0);
        check("R11 rnd done attn", attn, f < 20);
        rd(0, d); check("R11 rnd go", d[0], 0);
      end
      rd(2, d); check("R6 rnd err", d, pe);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule